// File: doc/BRIEF.md
# Card Detect Debounce Tracker

This block turns a noisy, active-low card-detect contact into a clean card-present status for a removable-card host controller. The detect pin and the write-protect pin each pass through a clock-domain synchronizer. The synchronized detect level then feeds a settle counter. The counter reports that the contact has settled only after the level has held still for a programmable number of cycles. The presence flag is committed only at that moment, so contact bounce never reaches it.

Each committed change of presence produces a one-cycle interrupt pulse: one pulse for insertion and a different one for removal. If a card is pulled out while bus power and the card clock are both enabled, the block also issues one-cycle clear strobes for those two enable bits, so the card is not left powered without a card in the slot.

The controller-wide software reset leaves the debounce state and the presence flag alone. It only masks interrupt pulses while it is held. Detection does not depend on whether bus power is on.

Top module: `card_detect_tracker`

## Requirements
- R1: `detect_level` is the inverse of `detect_n_pin`, delayed by the two synchronizer flops (1 = pin low = card present). It reads 0 during power-on reset.
- R2: `wp_level` follows `wp_pin` through the two synchronizer flops. 0 means the pin is low and writes are protected; 1 means the pin is high and writes are allowed. It reads 0 during reset.
- R3: `settled` is 0 after reset. It becomes 1 once the synchronized detect level has stayed unchanged for SETTLE_CYCLES consecutive cycles. Any change of that level clears `settled` and restarts the count.
- R4: `card_present` is 0 after reset. It changes only in the cycle in which `settled` rises, and it then takes the synchronized detect level (1 when the pin is low). A bounce shorter than the settle time leaves it unchanged.
- R5: `insert_pulse` is high for exactly one cycle when `card_present` goes from 0 to 1. `remove_pulse` is high for exactly one cycle when it goes from 1 to 0. Neither pulse fires at any other time.
- R6: `power_off_strobe` and `clock_off_strobe` pulse together, for one cycle, alongside `remove_pulse`. They do so only when `bus_power_on` and `clk_enable_on` were both 1 in the cycle in which the removal was committed. They never pulse otherwise.
- R7: `sw_reset_all` does not change `settled` or `card_present`. Detection works with `bus_power_on` at either value.
- R8: While `sw_reset_all` is high at the commit cycle, `insert_pulse` and `remove_pulse` are suppressed, but `card_present` is still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sw_reset_all | input | 1 | Controller-wide software reset; masks interrupt pulses only |
| detect_n_pin | input | 1 | Raw card-detect contact, low when a card is in the slot |
| wp_pin | input | 1 | Raw write-protect contact, high when writes are allowed |
| bus_power_on | input | 1 | Current bus power enable setting |
| clk_enable_on | input | 1 | Current card clock enable setting |
| detect_level | output | 1 | Synchronized inverse of the detect contact |
| wp_level | output | 1 | Synchronized write-protect contact |
| settled | output | 1 | Detect level has been stable for the settle time |
| card_present | output | 1 | Debounced card-present flag |
| insert_pulse | output | 1 | One-cycle card insertion interrupt |
| remove_pulse | output | 1 | One-cycle card removal interrupt |
| power_off_strobe | output | 1 | One-cycle request to clear bus power enable |
| clock_off_strobe | output | 1 | One-cycle request to clear card clock enable |

## Verification
The bench drives clean insertions and removals with the power and clock settings in each combination, so it can tell a plain removal from one that must also strobe the enables off. It injects bounces shorter than the settle time, which separates a dropped `settled` flag from a wrongly committed presence change. Pulses of the software reset inside a settle window, and a reset held across a commit, distinguish the preserved debounce state from the masked interrupt pulses.

// File: rtl/card_detect_tracker.sv
module card_detect_tracker #(
  parameter int unsigned SETTLE_CYCLES = 65536,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset_all,
  input  logic detect_n_pin,
  input  logic wp_pin,
  input  logic bus_power_on,
  input  logic clk_enable_on,
  output logic detect_level,
  output logic wp_level,
  output logic settled,
  output logic card_present,
  output logic insert_pulse,
  output logic remove_pulse,
  output logic power_off_strobe,
  output logic clock_off_strobe
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] cd_sync, wp_sync;
  logic cd_s, cd_last;
  logic [CW-1:0] cnt;
  logic settle_now, present_next, pull_hot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cd_sync <= '1;
      wp_sync <= '0;
    end else begin
      cd_sync <= {cd_sync[SYNC_STAGES-2:0], detect_n_pin};
      wp_sync <= {wp_sync[SYNC_STAGES-2:0], wp_pin};
    end

  assign cd_s         = cd_sync[SYNC_STAGES-1];
  assign detect_level = ~cd_s;
  assign wp_level     = wp_sync[SYNC_STAGES-1];
  assign present_next = ~cd_s;
  assign settle_now   = (cd_s == cd_last) && !settled && (cnt == LAST);
  assign pull_hot     = settle_now && !present_next && card_present;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cd_last <= 1'b1;
      cnt     <= '0;
      settled <= 1'b0;
    end else begin
      cd_last <= cd_s;
      if (cd_s != cd_last) begin
        cnt     <= '0;
        settled <= 1'b0;
      end else if (!settled) begin
        if (cnt == LAST) settled <= 1'b1;
        else             cnt     <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      card_present     <= 1'b0;
      insert_pulse     <= 1'b0;
      remove_pulse     <= 1'b0;
      power_off_strobe <= 1'b0;
      clock_off_strobe <= 1'b0;
    end else begin
      if (settle_now) card_present <= present_next;
      insert_pulse     <= settle_now && present_next && !card_present && !sw_reset_all;
      remove_pulse     <= pull_hot && !sw_reset_all;
      power_off_strobe <= pull_hot && bus_power_on && clk_enable_on;
      clock_off_strobe <= pull_hot && bus_power_on && clk_enable_on;
    end
endmodule

module card_detect_tracker_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic sw_reset_all,
  input logic detect_n_pin,
  input logic wp_pin,
  input logic bus_power_on,
  input logic clk_enable_on,
  input logic detect_level,
  input logic wp_level,
  input logic settled,
  input logic card_present,
  input logic insert_pulse,
  input logic remove_pulse,
  input logic power_off_strobe,
  input logic clock_off_strobe
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;

  generate if (SYNC_STAGES == 2) begin : g_sync
    // R1
    detect_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (detect_level == !$past(detect_n_pin, 2)));
    // R2
    wp_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (wp_level == $past(wp_pin, 2)));
  end endgenerate

  // R4
  present_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(card_present) |-> $rose(settled));
  // R5
  insert_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insert_pulse |-> $rose(card_present));
  // R5
  remove_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remove_pulse |-> $fell(card_present));
  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insert_pulse || remove_pulse) |=> !(insert_pulse || remove_pulse));
  // R6
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_off_strobe == clock_off_strobe);
  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_off_strobe |-> ($fell(card_present) && $past(bus_power_on && clk_enable_on)));
  // R8
  sw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_reset_all) |-> !(insert_pulse || remove_pulse));
endmodule

bind card_detect_tracker card_detect_tracker_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/card_detect_tracker_tb.sv
module card_detect_tracker_tb;
  localparam int unsigned SETTLE = 16;
  localparam int unsigned WAIT   = SETTLE + 8;

  logic clk = 1'b0, rst_n = 1'b0, sw_reset_all = 1'b0;
  logic detect_n_pin = 1'b1, wp_pin = 1'b0, bus_power_on = 1'b0, clk_enable_on = 1'b0;
  logic detect_level, wp_level, settled, card_present;
  logic insert_pulse, remove_pulse, power_off_strobe, clock_off_strobe;
  int checks = 0, failures = 0;
  logic [2:0] exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  card_detect_tracker #(.SETTLE_CYCLES(SETTLE)) u_dut (.*);

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // expected item: {insert, remove, strobe}
  task automatic expect_event(logic [2:0] ev);
    exp_q.push_back(ev);
  endtask

  always @(negedge clk) if (rst_n && (insert_pulse || remove_pulse || power_off_strobe || clock_off_strobe)) begin
    logic [2:0] got, want;
    got = {insert_pulse, remove_pulse, power_off_strobe & clock_off_strobe};
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL R5/R6 unexpected event actual=%b expected=none", got);
    end else begin
      want = exp_q.pop_front();
      if (got !== want || power_off_strobe !== clock_off_strobe) begin
        failures++;
        $display("FAIL R5/R6 event actual=%b expected=%b", got, want);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check("R3 reset settled", settled, 1'b0);
    check("R4 reset present", card_present, 1'b0);
    check("R1 reset level", detect_level, 1'b0);
    rst_n = 1'b1;
    cycles(3);
    check("R1 no card level", detect_level, 1'b0);
    check("R2 protected", wp_level, 1'b0);
    cycles(WAIT);
    check("R3 settled idle", settled, 1'b1);
    check("R4 idle absent", card_present, 1'b0);

    // R7: insert with bus power off
    expect_event(3'b100);
    detect_n_pin = 1'b0;
    cycles(4);
    check("R3 change drops settled", settled, 1'b0);
    check("R1 card level", detect_level, 1'b1);
    check("R4 no early commit", card_present, 1'b0);
    cycles(WAIT);
    check("R3 settled after insert", settled, 1'b1);
    check("R4 present", card_present, 1'b1);

    // R3/R4: short bounce
    detect_n_pin = 1'b1;
    cycles(5);
    detect_n_pin = 1'b0;
    cycles(4);
    check("R3 bounce drops settled", settled, 1'b0);
    check("R4 bounce keeps present", card_present, 1'b1);
    cycles(WAIT);
    check("R3 resettled", settled, 1'b1);
    check("R4 still present", card_present, 1'b1);

    wp_pin = 1'b1;
    cycles(3);
    check("R2 writable", wp_level, 1'b1);

    // R6: removal with power on, clock off -> no strobes
    bus_power_on = 1'b1;
    expect_event(3'b010);
    detect_n_pin = 1'b1;
    cycles(WAIT);
    check("R4 removed", card_present, 1'b0);

    // R7: software reset inside settle window
    expect_event(3'b100);
    detect_n_pin = 1'b0;
    cycles(6);
    sw_reset_all = 1'b1;
    cycles(2);
    check("R7 sw reset keeps settled", settled, 1'b0);
    check("R7 sw reset keeps present", card_present, 1'b0);
    sw_reset_all = 1'b0;
    cycles(WAIT);
    check("R7 present after sw reset", card_present, 1'b1);
    sw_reset_all = 1'b1;
    cycles(2);
    check("R7 sw reset settled held", settled, 1'b1);
    check("R7 sw reset present held", card_present, 1'b1);
    sw_reset_all = 1'b0;

    // R6: hot removal with power and clock on -> strobes
    clk_enable_on = 1'b1;
    expect_event(3'b011);
    detect_n_pin = 1'b1;
    cycles(WAIT);
    check("R4 hot removed", card_present, 1'b0);

    // R8: insertion committed under software reset -> no pulse
    sw_reset_all = 1'b1;
    detect_n_pin = 1'b0;
    cycles(WAIT);
    check("R8 present updated", card_present, 1'b1);
    sw_reset_all = 1'b0;
    cycles(4);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R5 missing events actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule